// File: doc/BRIEF.md
# Peripheral Clock-Gating Power Controller

This block decides which on-chip peripherals receive a clock. Software writes a power-mode register over a simple register bus. The register holds a power-down bit for each of six peripherals: a timer, two UARTs, a serial peripheral interface, a parallel port and a USB function. The block turns these bits into registered clock-enable lines.

The two UARTs and the USB function can each be armed to wake themselves. Activity on a watched line then clears the peripheral's power-down bit in hardware, and its clock comes back without software help.

The block also controls a whole-chip stop state, which takes three steps:
- Software sets a stop-arm bit.
- Software writes a separate activate register.
- The core raises a halt-request pulse.

While stopped, every clock enable is low and a bus-quiesce output tells the bus logic to drive the data lines low and hold its controls negated. Any of six external interrupt lines ends the stop state.

Top module: `pwrctl_top`

## Requirements
- R1: The power-mode register is at address 0. Bits 0 to 5 are the power-down bits for timer, UART0, UART1, SPI, parallel port and USB, in that order. Outside stop, `clk_en[i]` equals the inverse of power-down bit i: 1 means the clock runs. It changes at the same clock edge that writes the register.
- R2: Reset clears all power-down, wake and stop-arm bits and the stop state. `clk_en` then reads 6'h3F, and `stop_mode` and `bus_quiesce` read 0.
- R3: Only bits 0 to 5, bits 8 to 10 and bit 16 are stored. All other bit positions read back as zero. A read is requested with `reg_re`, and `reg_rdata` is valid after the next clock edge. Reading address 1 returns zero.
- R4: Bits 8, 9 and 10 are the wake-enable bits for UART0, UART1 and USB. A level change on a watched line clears the matching power-down bit only when both the wake-enable bit and that power-down bit are set. The wake-enable bit itself stays set.
- R5: UART0 watches `uart0_rx` and UART1 watches `uart1_rx`. USB watches both `usb_dp` and `usb_wake_pin`.
- R6: Every asynchronous input passes through a two-flop synchronizer. A level change is found by comparing the synchronized value with its value one cycle earlier.
- R7: Stop mode is entered only when all of the following hold: stop-arm (bit 16) is set, a write to the activate register (address 1, any data) happened while stop-arm was set, and `halt_req` is then high for a cycle. Setting stop-arm alone, or a halt request without a prior activate, leaves the block running.
- R8: While in stop mode, all `clk_en` bits are 0 and `bus_quiesce` is 1, whatever the power-down bits hold.
- R9: A synchronized high level on any `ext_irq` line ends stop mode. On exit, the clock enables return to the inverse of the power-down bits, and a new activate write is needed before the next stop.
- R10: If a software write and a hardware wake clear hit the same power-down bit in the same cycle, the hardware clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address (0 mode, 1 activate) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| halt_req | input | 1 | Halt request pulse from the core |
| uart0_rx | input | 1 | UART0 receive line, asynchronous |
| uart1_rx | input | 1 | UART1 receive line, asynchronous |
| usb_dp | input | 1 | USB D+ line, asynchronous |
| usb_wake_pin | input | 1 | USB wake/interrupt pin, asynchronous |
| ext_irq | input | NIRQ | External interrupt lines, asynchronous |
| clk_en | output | 6 | Clock enable per peripheral, bit order as in R1 |
| stop_mode | output | 1 | High while the chip is stopped |
| bus_quiesce | output | 1 | High to force data low and negate bus controls |

## Verification
The assertions check the following on every cycle:
- outside stop, the clock enables track the power-down bits;
- in stop, the clock enables are all low;
- an armed wake event clears its power-down bit at the next edge;
- a power-down bit never falls without a write unless its wake bit was armed;
- entry into stop is always preceded by an activate plus a halt request;
- a synchronized interrupt always ends the stop state.

Some properties can only be shown by the bench's scenarios. These are:
- the reset values;
- the reserved bits that read as zero;
- the line-to-enable latency through the synchronizers;
- the USB wake on either of its two lines;
- that an activate alone or an arm alone does not stop the chip;
- the one-cycle conflict between a write and a hardware clear.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int DW      = 32;
  localparam int NPER    = 6;
  localparam int P_TMR   = 0;
  localparam int P_U0    = 1;
  localparam int P_U1    = 2;
  localparam int P_SPI   = 3;
  localparam int P_PAR   = 4;
  localparam int P_USB   = 5;
  localparam int NWK     = 3;   // wake channels: 0 uart0, 1 uart1, 2 usb
  localparam int WK_LSB  = 8;
  localparam int ARM_BIT = 16;
  localparam logic [DW-1:0] PM_MASK = 32'h0001_073F;

  function automatic int wk_per(input int ch);
    case (ch)
      0:       return P_U0;
      1:       return P_U1;
      default: return P_USB;
    endcase
  endfunction
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= '0;
    else     ff <= {ff[STAGES-2:0], din};
  end

  assign dout = ff[STAGES-1];
endmodule

// File: rtl/pwr_chg.sv
module pwr_chg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= din;
  end

  assign chg = din ^ prev_q;
endmodule

// File: rtl/pwr_regs.sv
module pwr_regs
  import pwr_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int PM_ADDR  = 0,
  parameter int ACT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NWK-1:0]    wk_chg,
  output logic [NPER-1:0]   pdn_q,
  output logic [NPER-1:0]   pdn_nxt,
  output logic              arm_q,
  output logic              act_wr
);
  logic [NWK-1:0]  wake_q, wake_nxt, fire;
  logic [NPER-1:0] hw_clr;
  logic            arm_nxt, pm_wr;
  logic [DW-1:0]   pm_view;

  always_comb begin
    pm_wr  = reg_we && (reg_addr == ADDR_W'(PM_ADDR));
    act_wr = reg_we && (reg_addr == ADDR_W'(ACT_ADDR));
    fire   = wake_q & wk_chg;
    hw_clr = '0;
    for (int c = 0; c < NWK; c++) begin
      fire[c] = fire[c] & pdn_q[wk_per(c)];
      hw_clr[wk_per(c)] = hw_clr[wk_per(c)] | fire[c];
    end
    pdn_nxt  = (pm_wr ? reg_wdata[NPER-1:0] : pdn_q) & ~hw_clr;
    wake_nxt = pm_wr ? reg_wdata[WK_LSB +: NWK] : wake_q;
    arm_nxt  = pm_wr ? reg_wdata[ARM_BIT] : arm_q;
    pm_view  = '0;
    pm_view[NPER-1:0]        = pdn_q;
    pm_view[WK_LSB +: NWK]   = wake_q;
    pm_view[ARM_BIT]         = arm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pdn_q     <= '0;
      wake_q    <= '0;
      arm_q     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      pdn_q  <= pdn_nxt;
      wake_q <= wake_nxt;
      arm_q  <= arm_nxt;
      if (reg_re)
        reg_rdata <= (reg_addr == ADDR_W'(PM_ADDR)) ? (pm_view & PM_MASK) : '0;
    end
  end

  for (genvar c = 0; c < NWK; c++) begin : g_wk_chk
    // R4, R10: an armed wake event clears its power-down bit at the next edge
    a_r4_wake_clears: assert property (@(posedge clk) disable iff (rst)
      fire[c] |=> !pdn_q[wk_per(c)]);
    // R4: without a write, a power-down bit only falls if its wake bit was armed
    a_r4_fall_needs_wake: assert property (@(posedge clk) disable iff (rst)
      ($fell(pdn_q[wk_per(c)]) && !$past(pm_wr)) |-> $past(wake_q[c]));
  end
endmodule

// File: rtl/pwr_stop.sv
module pwr_stop #(
  parameter int NIRQ   = 6,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            arm,
  input  logic            act_wr,
  input  logic            halt_req,
  input  logic [NIRQ-1:0] irq_raw,
  output logic            stop_nxt,
  output logic            stop_q,
  output logic            quiesce_q
);
  logic [NIRQ-1:0] irq_s;
  logic            irq_any, go_q, go_nxt;

  pwr_sync #(.W(NIRQ), .STAGES(STAGES)) u_irq_sync (
    .clk(clk), .rst(rst), .din(irq_raw), .dout(irq_s));

  always_comb begin
    irq_any  = |irq_s;
    stop_nxt = stop_q ? !irq_any : (go_q && halt_req);
    go_nxt   = go_q;
    if (!arm || (stop_q && irq_any)) go_nxt = 1'b0;
    else if (act_wr)                 go_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q    <= 1'b0;
      quiesce_q <= 1'b0;
      go_q      <= 1'b0;
    end else begin
      stop_q    <= stop_nxt;
      quiesce_q <= stop_nxt;
      go_q      <= go_nxt;
    end
  end

  // R7: entry only after activate and a halt request
  a_r7_entry_needs_go: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_q) |-> ($past(go_q) && $past(halt_req)));
  // R9: a synchronized interrupt ends stop at the next edge
  a_r9_irq_exit: assert property (@(posedge clk) disable iff (rst)
    (stop_q && irq_any) |=> !stop_q);
endmodule

// File: rtl/pwrctl_top.sv
module pwrctl_top
  import pwr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int NIRQ   = 6,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              halt_req,
  input  logic              uart0_rx,
  input  logic              uart1_rx,
  input  logic              usb_dp,
  input  logic              usb_wake_pin,
  input  logic [NIRQ-1:0]   ext_irq,
  output logic [5:0]        clk_en,
  output logic              stop_mode,
  output logic              bus_quiesce
);
  localparam int NLINE = 4;

  logic [NLINE-1:0] line_s, line_chg;
  logic [NWK-1:0]   wk_chg;
  logic [NPER-1:0]  pdn_q, pdn_nxt;
  logic             arm_q, act_wr, stop_nxt;

  pwr_sync #(.W(NLINE), .STAGES(STAGES)) u_line_sync (
    .clk(clk), .rst(rst),
    .din({usb_wake_pin, usb_dp, uart1_rx, uart0_rx}), .dout(line_s));

  pwr_chg #(.W(NLINE)) u_line_chg (
    .clk(clk), .rst(rst), .din(line_s), .chg(line_chg));

  assign wk_chg = {line_chg[3] | line_chg[2], line_chg[1], line_chg[0]};

  pwr_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wk_chg(wk_chg), .pdn_q(pdn_q), .pdn_nxt(pdn_nxt),
    .arm_q(arm_q), .act_wr(act_wr));

  pwr_stop #(.NIRQ(NIRQ), .STAGES(STAGES)) u_stop (
    .clk(clk), .rst(rst), .arm(arm_q), .act_wr(act_wr),
    .halt_req(halt_req), .irq_raw(ext_irq), .stop_nxt(stop_nxt),
    .stop_q(stop_mode), .quiesce_q(bus_quiesce));

  always_ff @(posedge clk) begin
    if (rst)           clk_en <= '1;
    else if (stop_nxt) clk_en <= '0;
    else               clk_en <= ~pdn_nxt;
  end

  // R1: outside stop the enables follow the power-down bits
  a_r1_en_follows_pdn: assert property (@(posedge clk) disable iff (rst)
    !stop_mode |-> (clk_en == ~pdn_q));
  // R8: all clocks gated and bus quiesced in stop
  a_r8_stop_gates_all: assert property (@(posedge clk) disable iff (rst)
    stop_mode |-> (clk_en == '0 && bus_quiesce));
endmodule

// File: tb/sim_pwrctl_top.sv
module sim_pwrctl_top;
  logic        clk = 0, rst = 1, reg_we = 0, reg_re = 0, halt_req = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        uart0_rx = 1, uart1_rx = 1, usb_dp = 0, usb_wake_pin = 0;
  logic [5:0]  ext_irq = 0, clk_en;
  logic        stop_mode, bus_quiesce;
  int          total = 0, bad = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  pwrctl_top u0 (.clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .halt_req(halt_req), .uart0_rx(uart0_rx), .uart1_rx(uart1_rx),
    .usb_dp(usb_dp), .usb_wake_pin(usb_wake_pin), .ext_irq(ext_irq),
    .clk_en(clk_en), .stop_mode(stop_mode), .bus_quiesce(bus_quiesce));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1; reg_addr = a;
    @(negedge clk); reg_re = 0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R2 clk_en", 32'(clk_en), 32'h3F);
    chk("R2 stop", 32'({stop_mode, bus_quiesce}), 0);
    rdreg(0, rd); chk("R2 reg", rd, 0);
  endtask

  task automatic t_pdn;
    wr(0, 32'h15);
    chk("R1 pattern a", 32'(clk_en), 32'h2A);
    wr(0, 32'h2A);
    chk("R1 pattern b", 32'(clk_en), 32'h15);
    rdreg(0, rd); chk("R1 readback", rd, 32'h2A);
    wr(0, 32'h0);
    chk("R1 all on", 32'(clk_en), 32'h3F);
  endtask

  task automatic t_rsvd;
    wr(0, 32'hFFFE_F8C0);
    rdreg(0, rd); chk("R3 reserved zero", rd, 0);
    wr(0, 32'hFFFF_FFFF);
    rdreg(0, rd); chk("R3 masked", rd, 32'h0001_073F);
    rdreg(1, rd); chk("R3 activate reads zero", rd, 0);
    wr(0, 0);
  endtask

  task automatic t_wake_unarmed;
    wr(0, 32'h0000_0002);            // uart0 off, no wake
    @(negedge clk); uart0_rx = 0; idle(5);
    chk("R4 no wake without enable", 32'(clk_en), 32'h3D);
    wr(0, 32'h0000_0100);            // wake armed, pdn clear
    @(negedge clk); uart0_rx = 1; idle(5);
    rdreg(0, rd); chk("R4 wake without pdn", rd, 32'h100);
  endtask

  task automatic t_wake_uart;
    wr(0, 32'h0000_0306);            // uart0+uart1 off, both wake
    chk("R5 uarts off", 32'(clk_en), 32'h39);
    @(negedge clk); uart1_rx = 0; idle(5);
    chk("R5 uart1 wakes", 32'(clk_en), 32'h3D);
    @(negedge clk); uart0_rx = 0; idle(5);
    chk("R5 uart0 wakes", 32'(clk_en), 32'h3F);
    rdreg(0, rd); chk("R4 wake bits kept", rd, 32'h300);
    uart0_rx = 1; uart1_rx = 1; idle(5);
  endtask

  task automatic t_wake_usb;
    wr(0, 32'h0000_0420);
    @(negedge clk); usb_dp = 1; idle(5);
    chk("R5 usb via dp", 32'(clk_en), 32'h3F);
    wr(0, 32'h0000_0420);
    @(negedge clk); usb_wake_pin = 1; idle(5);
    chk("R5 usb via pin", 32'(clk_en), 32'h3F);
  endtask

  task automatic t_sync_lat;
    wr(0, 32'h0000_0102);
    @(negedge clk); uart0_rx = 0;
    idle(2);
    chk("R6 still off after 2", 32'(clk_en), 32'h3D);
    idle(1);
    chk("R6 on after 3", 32'(clk_en), 32'h3F);
    uart0_rx = 1; idle(5);
  endtask

  task automatic t_conflict;
    wr(0, 32'h0000_0102);
    @(negedge clk); uart0_rx = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_we = 1; reg_addr = 0; reg_wdata = 32'h0000_0103;
    @(negedge clk); reg_we = 0;
    chk("R10 hw clear wins", 32'(clk_en), 32'h3E);
    uart0_rx = 1; idle(5);
    wr(0, 0);
  endtask

  task automatic pulse_halt;
    @(negedge clk); halt_req = 1; @(negedge clk); halt_req = 0;
  endtask

  task automatic t_stop;
    wr(0, 32'h0001_0008);
    pulse_halt;
    chk("R7 arm alone", 32'(stop_mode), 0);
    wr(0, 32'h0000_0008); wr(1, 0); wr(0, 32'h0001_0008);
    pulse_halt;
    chk("R7 activate before arm", 32'(stop_mode), 0);
    wr(1, 0); idle(3);
    chk("R7 activate needs halt", 32'(stop_mode), 0);
    pulse_halt;
    chk("R7 stop entered", 32'(stop_mode), 1);
    chk("R8 gated", 32'(clk_en), 0);
    chk("R8 quiesce", 32'(bus_quiesce), 1);
    @(negedge clk); ext_irq = 6'b100000; idle(4);
    chk("R9 exit", 32'({stop_mode, bus_quiesce}), 0);
    chk("R9 enables restored", 32'(clk_en), 32'h37);
    ext_irq = 0; idle(4);
    pulse_halt;
    chk("R9 re-activate needed", 32'(stop_mode), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    idle(4);
    t_reset;
    t_pdn;
    t_rsvd;
    t_wake_unarmed;
    t_wake_uart;
    t_wake_usb;
    t_sync_lat;
    t_conflict;
    t_stop;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule